// File: doc/BRIEF.md
# Multi-Mode Up/Down Period Timer

This block is a free-standing counter for timekeeping and periodic events. A two-bit mode field picks one of four behaviours: hold the count, count up to a programmable period and restart from zero, count through the whole range, or count up to the period and back down to zero in a triangle. The count moves only on cycles where the timer clock enable is high. The rest of the block runs on the system clock with a synchronous reset.

Writing the mode field is the only way to start or stop the timer, and a mode change leaves the count as it was. In triangle mode the timer also keeps the direction it was moving in. After a stop and restart it carries on from the held value in that direction. A self-clearing clear pulse sets the count to zero and the direction to up. Two sticky flags mark the count reaching the period value and the count returning to zero. Each flag is combined with its own enable and a global enable to drive an interrupt request line.

Top module: `updown_period_timer`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up) and both flags are 0.
- R2: With mode 00 (stop) the count and direction hold. A change of mode never alters the count value.
- R3: With mode 01 (up), each enabled tick adds one while the count is below the period. When the count equals or exceeds the period, the tick returns it to 0.
- R4: With mode 10 (continuous), each enabled tick adds one, and the maximum value (all ones) wraps to 0.
- R5: With mode 11 (up/down) the count rises to the period, then falls, with dir_down high, until it reaches 0, and then rises again. A tick taken at count 0 with a period of 0 leaves the count at 0.
- R6: The up/down direction is kept while the timer is stopped or in another mode. On return to mode 11, counting resumes from the held value in the stored direction.
- R7: A clear pulse sets the count to 0 and the direction to up on the next clock edge. Clear takes priority over a tick, and a tick in the same cycle sets no flag.
- R8: The count changes only on cycles where tick is high, apart from clear.
- R9: cmp_flag sets when a tick in any non-stop mode leaves the count equal to the period.
- R10: roll_flag sets when a tick returns the count to 0 in three cases: in up mode from a value at or above the period, in continuous mode from all ones, and in up/down mode while moving down.
- R11: The flags stay set until their own clear strobe. A set event in the same cycle as the strobe wins, and the flag stays set.
- R12: cmp_irq is cmp_flag AND cmp_ie AND gie. roll_irq is roll_flag AND roll_ie AND gie. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer clock enable |
| mode | input | 2 | 00 stop, 01 up, 10 continuous, 11 up/down |
| clear | input | 1 | Clear count and direction (pulse) |
| period | input | W | Period compare value |
| cmp_ie | input | 1 | Compare flag interrupt enable |
| roll_ie | input | 1 | Rollover flag interrupt enable |
| gie | input | 1 | Global interrupt enable |
| cmp_flag_clr | input | 1 | Clear strobe for cmp_flag |
| roll_flag_clr | input | 1 | Clear strobe for roll_flag |
| count | output | W | Current count |
| dir_down | output | 1 | Stored up/down direction, 1 = down |
| cmp_flag | output | 1 | Sticky compare-equal flag |
| roll_flag | output | 1 | Sticky rollover flag |
| cmp_irq | output | 1 | Compare interrupt request |
| roll_irq | output | 1 | Rollover interrupt request |

## Verification
The bench builds the timer with W = 8. With that width a full continuous-mode wrap takes 256 ticks, so random runs pass through the all-ones rollover many times. Periods are drawn mostly small, which puts triangle turnarounds at periods 0 and 1, periods lowered below the live count, and direction carried across stops and mode changes within a few cycles of each other. Clear pulses and flag clear strobes are mixed in at random, so both priority rules occur against every mode.

// File: rtl/updown_period_timer.sv
module updown_period_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic         clear,
  input  logic [W-1:0] period,
  input  logic         cmp_ie,
  input  logic         roll_ie,
  input  logic         gie,
  input  logic         cmp_flag_clr,
  input  logic         roll_flag_clr,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         cmp_flag,
  output logic         roll_flag,
  output logic         cmp_irq,
  output logic         roll_irq
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP  = '1;

  logic [W-1:0] nxt;
  logic         nxt_down, roll_set, cmp_set, fall;

  always_comb begin
    nxt      = count;
    nxt_down = dir_down;
    roll_set = 1'b0;
    fall     = 1'b0;
    if (tick) begin
      case (mode)
        2'b01: begin
          if (count >= period) begin
            nxt      = ZERO;
            roll_set = 1'b1;
          end else begin
            nxt = count + ONE;
          end
        end
        2'b10: begin
          nxt      = count + ONE;
          roll_set = (count == TOP);
        end
        2'b11: begin
          if (dir_down) fall = 1'b1;
          else if (count >= period && count != ZERO) fall = 1'b1;
          else if (count < period) nxt = count + ONE;
          if (fall) begin
            if (count <= ONE) begin
              nxt      = ZERO;
              nxt_down = 1'b0;
              roll_set = 1'b1;
            end else begin
              nxt      = count - ONE;
              nxt_down = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign cmp_set = tick && (mode != 2'b00) && (nxt == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= ZERO;
      dir_down  <= 1'b0;
      cmp_flag  <= 1'b0;
      roll_flag <= 1'b0;
    end else begin
      if (clear) begin
        count    <= ZERO;
        dir_down <= 1'b0;
      end else begin
        count    <= nxt;
        dir_down <= nxt_down;
      end
      cmp_flag  <= (cmp_set && !clear) || (cmp_flag && !cmp_flag_clr);
      roll_flag <= (roll_set && !clear) || (roll_flag && !roll_flag_clr);
    end
  end

  assign cmp_irq  = cmp_flag && cmp_ie && gie;
  assign roll_irq = roll_flag && roll_ie && gie;
endmodule

module updown_period_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [1:0]   mode,
  input logic         clear,
  input logic [W-1:0] period,
  input logic         cmp_flag_clr,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         cmp_flag,
  input logic         roll_flag,
  input logic         cmp_irq
);
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && (mode == 2'b00 || !tick)) |=> (count == $past(count) && dir_down == $past(dir_down))); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0 && !dir_down)); // R7
  AST_CONT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clear && tick && mode == 2'b10) |=> (count == $past(count) + 1'b1)); // R4
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clear && tick && mode == 2'b01 && count >= period) |=> (count == '0)); // R3
  AST_ROLL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(roll_flag) |-> (count == '0)); // R10
  AST_CMP_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> (count == $past(period))); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !cmp_flag_clr) |=> cmp_flag); // R11
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> cmp_flag); // R12
endmodule

bind updown_period_timer updown_period_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .mode(mode), .clear(clear),
  .period(period), .cmp_flag_clr(cmp_flag_clr), .count(count),
  .dir_down(dir_down), .cmp_flag(cmp_flag), .roll_flag(roll_flag),
  .cmp_irq(cmp_irq)
);

// File: tb/updown_period_timer_tb.sv
`timescale 1ns/1ps
module updown_period_timer_tb_top;
  localparam int W = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, clear = 0, cie = 0, rie = 0, gie = 0, cclr = 0, rclr = 0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] per = '0;
  logic [W-1:0] count;
  logic dir_down, cmp_flag, roll_flag, cmp_irq, roll_irq;

  int checks = 0, errors = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_down = 0, m_cf = 0, m_rf = 0;

  always #4 clk = ~clk;

  updown_period_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .clear(clear), .period(per),
    .cmp_ie(cie), .roll_ie(rie), .gie(gie), .cmp_flag_clr(cclr), .roll_flag_clr(rclr),
    .count(count), .dir_down(dir_down), .cmp_flag(cmp_flag), .roll_flag(roll_flag),
    .cmp_irq(cmp_irq), .roll_irq(roll_irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [W-1:0] n;
    logic d, r, c, dn;
    n = m_cnt; d = m_down; r = 0; c = 0;
    if (rst) begin
      m_cnt = '0; m_down = 0; m_cf = 0; m_rf = 0;
      return;
    end
    if (tick && mode != 2'b00) begin
      if (mode == 2'b01) begin
        if (m_cnt >= per) begin n = '0; r = 1; end else n = m_cnt + 1'b1;
      end else if (mode == 2'b10) begin
        n = m_cnt + 1'b1; r = (m_cnt == 8'hFF);
      end else begin
        dn = m_down || (m_cnt >= per && m_cnt != 0);
        if (dn) begin
          if (m_cnt <= 1) begin n = '0; d = 0; r = 1; end
          else begin n = m_cnt - 1'b1; d = 1; end
        end else if (m_cnt < per) n = m_cnt + 1'b1;
      end
      c = (n == per);
    end
    if (clear) begin n = '0; d = 0; r = 0; c = 0; end
    m_cf = c || (m_cf && !cclr);
    m_rf = r || (m_rf && !rclr);
    m_cnt = n; m_down = d;
  endtask

  task automatic compare();
    string ct;
    if (clear) ct = "R7";
    else if (!tick) ct = "R8";
    else case (mode)
      2'b00: ct = "R2";
      2'b01: ct = "R3";
      2'b10: ct = "R4";
      default: ct = "R5";
    endcase
    model_update();
    @(negedge clk);
    chk({ct, " count"}, int'(count), int'(m_cnt));
    chk((mode == 2'b11) ? "R5 dir" : "R6 dir", int'(dir_down), int'(m_down));
    chk((cclr || rclr) ? "R11 cmp_flag" : "R9 cmp_flag", int'(cmp_flag), int'(m_cf));
    chk((cclr || rclr) ? "R11 roll_flag" : "R10 roll_flag", int'(roll_flag), int'(m_rf));
    chk("R12 cmp_irq", int'(cmp_irq), int'(m_cf && cie && gie));
    chk("R12 roll_irq", int'(roll_irq), int'(m_rf && rie && gie));
  endtask

  task automatic step();
    @(posedge clk);
    compare();
  endtask

  task automatic drive(input logic [1:0] md, input logic tk, input logic cl);
    mode = md; tick = tk; clear = cl; cclr = 0; rclr = 0;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dir_down), 0);
    chk("R1 flags", int'({cmp_flag, roll_flag}), 0);

    // continuous wrap
    per = 8'd100;
    drive(2'b10, 1, 0);
    repeat (255) step();
    chk("R4 at top", int'(count), 255);
    step();
    chk("R4 wrap", int'(count), 0);
    chk("R10 wrap flag", int'(roll_flag), 1);

    // up mode, period lowered under count
    drive(2'b01, 1, 1); step();
    chk("R7 clear", int'(count), 0);
    per = 8'd10; drive(2'b01, 1, 0);
    repeat (6) step();
    chk("R3 climb", int'(count), 6);
    per = 8'd3; rclr = 1; step();
    chk("R3 above period", int'(count), 0);
    chk("R10 above period", int'(roll_flag), 1);

    // up/down direction memory
    drive(2'b11, 0, 1); step();
    per = 8'd4; drive(2'b11, 1, 0);
    repeat (5) step();
    chk("R5 falling", int'(count), 3);
    chk("R5 dir", int'(dir_down), 1);
    drive(2'b00, 1, 0); repeat (3) step();
    chk("R2 held", int'(count), 3);
    drive(2'b11, 1, 0); step();
    chk("R6 resume down", int'(count), 2);
    chk("R6 dir kept", int'(dir_down), 1);
    drive(2'b11, 0, 0); repeat (2) step();
    chk("R8 no tick", int'(count), 2);
    drive(2'b11, 1, 1); step();
    chk("R7 clear count", int'(count), 0);
    chk("R7 clear dir", int'(dir_down), 0);

    // set beats clear strobe: up mode to period with cclr high
    per = 8'd2; drive(2'b01, 1, 0); step();
    cclr = 1; step();
    chk("R11 set wins", int'(cmp_flag), 1);
    cie = 1; gie = 0; drive(2'b00, 0, 0); step();
    chk("R12 gie off", int'(cmp_irq), 0);
    gie = 1; #1;
    chk("R12 gie on", int'(cmp_irq), 1);

    // random
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 20000; i++) begin
      mode  = ($urandom % 8 == 0) ? 2'($urandom) : mode;
      tick  = ($urandom % 4) != 0;
      clear = ($urandom % 40) == 0;
      cclr  = ($urandom % 10) == 0;
      rclr  = ($urandom % 10) == 0;
      cie   = ($urandom % 2) != 0;
      rie   = ($urandom % 2) != 0;
      gie   = ($urandom % 4) != 0;
      if ($urandom % 30 == 0)
        per = ($urandom % 4 == 0) ? W'($urandom) : W'($urandom % 8);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule